// File: doc/BRIEF.md
# I/O Transfer Controller with Skip, Interrupt and Clock Counter

This unit sits beside an 18-bit single-address processor. It turns I/O transfer instructions into work on the devices. When the processor hands it such an instruction, the unit latches a 6-bit device code and three command bits. It then runs a fixed three-slot pulse sequence, one slot per command bit. In each slot the unit can test the selected device's status line, gather parallel input or strobe the output word into the device.

The unit also owns the program-interrupt logic. The interrupt request is raised from device flags, or from the overflow of a clock counter word held in a small synchronous memory model. Each tick of an external 60 Hz strobe takes one memory cycle from the processor port and increments that word in place. A processor start or an interrupt acknowledge drops the interrupt enable. Only an explicit enable command raises it again.

Top module: `iot_ctrl`

## Requirements
- R1: An instruction is accepted only when `instr_valid` is high, bits 17..12 equal octal 70 and `busy` is low. Any other instruction, or any instruction offered while `busy` is high, produces no pulses, no select and no `busy`.
- R2: The device code is instruction bits 11..6. Device d answers to code DEV_BASE+d (DEV_BASE defaults to 1). `dev_sel` is one-hot for the matching device during the three slots and is all zero when no device matches.
- R3: `busy` is high for exactly three cycles after the accepting edge. `iop[k]` pulses in slot k+1 (bit 0 first, then bit 1, then bit 2) and only when instruction bit k is set.
- R4: `dout` holds `acc` as captured at the accepting edge. `dout_ld` pulses only for the selected device and only in the bit-2 slot.
- R5: In the bit-1 slot the bitwise OR of every device's `din` word is captured. `din_word` then holds that value, and `din_valid` is high for the following cycle only.
- R6: `skip` is high during the bit-0 slot exactly when bit 0 is set and the selected device's `dev_flag` is high.
- R7: `irq_req` equals `irq_en` AND (any `dev_flag` OR `rtc_ovf`).
- R8: Code 0 is the interrupt control code. Its bit-0 pulse clears `irq_en`, its bit-1 pulse sets `irq_en`, and its bit-2 pulse clears `rtc_ovf`.
- R9: Reset, `cpu_start` or `irq_ack` leaves `irq_en` low on the next cycle, and each takes priority over the enable command.
- R10: A `rtc_tick` increments the word at address RTC_ADDR (default 7) one cycle later. In that stolen cycle `mem_gnt` is low and no processor access takes place.
- R11: When the counter word is all ones, the increment wraps it to zero and sets `rtc_ovf`.
- R12: A granted processor write stores `mem_wdata`. A granted read returns the word on `mem_rdata` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_start | input | 1 | Processor start, clears interrupt enable |
| instr_valid | input | 1 | Instruction offered |
| instr | input | 18 | Instruction word |
| acc | input | 18 | Accumulator word for output |
| busy | output | 1 | Pulse sequence running |
| dev_sel | output | NDEV | One-hot selected device |
| iop | output | 3 | Command pulses |
| dout | output | 18 | Output word to devices |
| dout_ld | output | NDEV | Per-device output latch strobe |
| din | input | NDEV*18 | Device input words, device 0 in the low bits |
| din_word | output | 18 | Gathered input word |
| din_valid | output | 1 | Gathered word fresh |
| dev_flag | input | NDEV | Device status/flag lines |
| skip | output | 1 | Skip next instruction |
| irq_ack | input | 1 | Interrupt taken by processor |
| irq_en | output | 1 | Interrupt enable state |
| irq_req | output | 1 | Program interrupt request |
| rtc_tick | input | 1 | 60 Hz clock strobe, one cycle wide |
| rtc_ovf | output | 1 | Clock counter overflowed |
| mem_req | input | 1 | Processor memory request |
| mem_we | input | 1 | Processor write enable |
| mem_addr | input | AW | Processor address |
| mem_wdata | input | 18 | Processor write data |
| mem_gnt | output | 1 | Processor access granted this cycle |
| mem_rdata | output | 18 | Read data |

## Verification
The bench offers a second I/O instruction while a sequence is still running. A controller that restarted or stretched the sequence would show a fourth `busy` cycle. It uses a code that matches no device, where a faulty decode would strobe some device or report a skip. It drives a device flag with bit 0 clear, which must not skip, and drives several input words at once, which must merge by OR rather than by last-writer-wins. It holds a processor read pending across a tick, which exposes a grant given in the stolen cycle. It then steps the counter through the all-ones wrap: a design that missed the carry would never raise the overflow request. Finally it checks that an acknowledge kills the request until software enables it again.

// File: rtl/iot_pkg.sv
package iot_pkg;
    localparam int W        = 18;
    localparam int CODE_W   = 6;
    localparam int CMD_W    = 3;
    localparam logic [5:0] OP_IOT   = 6'o70;
    localparam logic [5:0] CTL_CODE = 6'o00;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_B0   = 2'd1,
        PH_B1   = 2'd2,
        PH_B2   = 2'd3
    } phase_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CMD_W-1:0]  cmd;
        logic [W-1:0]      data;
    } iot_cmd_t;

    function automatic logic is_iot(input logic [W-1:0] word);
        return word[W-1:W-6] == OP_IOT;
    endfunction

    function automatic iot_cmd_t unpack_iot(input logic [W-1:0] word,
                                            input logic [W-1:0] acc_w);
        iot_cmd_t c;
        c.code = word[11:6];
        c.cmd  = word[2:0];
        c.data = acc_w;
        return c;
    endfunction
endpackage

// File: rtl/iot_seq.sv
module iot_seq
    import iot_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           instr_valid,
    input  logic [W-1:0]   instr,
    input  logic [W-1:0]   acc,
    output logic           busy,
    output logic [2:0]     iop,
    output iot_cmd_t       cur
);
    phase_t phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cur   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (instr_valid && is_iot(instr)) begin
                    cur   <= unpack_iot(instr, acc);
                    phase <= PH_B0;
                end
                PH_B0:   phase <= PH_B1;
                PH_B1:   phase <= PH_B2;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy   = (phase != PH_IDLE);
    assign iop[0] = (phase == PH_B0) && cur.cmd[0];
    assign iop[1] = (phase == PH_B1) && cur.cmd[1];
    assign iop[2] = (phase == PH_B2) && cur.cmd[2];
endmodule

// File: rtl/iot_gather.sv
module iot_gather
    import iot_pkg::*;
#(
    parameter int NDEV     = 4,
    parameter int DEV_BASE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic [CODE_W-1:0] code,
    input  logic [2:0]        iop,
    input  logic [NDEV-1:0]   dev_flag,
    input  logic [NDEV*W-1:0] din,
    output logic [NDEV-1:0]   dev_sel,
    output logic [NDEV-1:0]   dout_ld,
    output logic              skip,
    output logic [W-1:0]      din_word,
    output logic              din_valid
);
    logic [W-1:0] or_chain [NDEV+1];

    assign or_chain[0] = '0;

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        localparam logic [CODE_W-1:0] MY_CODE = CODE_W'(DEV_BASE + d);
        assign dev_sel[d]    = busy && (code == MY_CODE);
        assign dout_ld[d]    = dev_sel[d] && iop[2];
        assign or_chain[d+1] = or_chain[d] | din[d*W +: W];
    end

    assign skip = iop[0] && |(dev_sel & dev_flag);

    always_ff @(posedge clk) begin
        if (rst) begin
            din_word  <= '0;
            din_valid <= 1'b0;
        end else begin
            din_valid <= iop[1];
            if (iop[1]) din_word <= or_chain[NDEV];
        end
    end
endmodule

// File: rtl/iot_irq.sv
module iot_irq (
    input  logic clk,
    input  logic rst,
    input  logic cpu_start,
    input  logic irq_ack,
    input  logic en_on,
    input  logic en_off,
    input  logic flag_any,
    input  logic rtc_ovf,
    output logic irq_en,
    output logic irq_req
);
    always_ff @(posedge clk) begin
        if (rst || cpu_start || irq_ack || en_off) irq_en <= 1'b0;
        else if (en_on)                            irq_en <= 1'b1;
    end

    assign irq_req = irq_en && (flag_any || rtc_ovf);
endmodule

// File: rtl/iot_mem.sv
module iot_mem
    import iot_pkg::*;
#(
    parameter int DEPTH    = 64,
    parameter int RTC_ADDR = 7,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rtc_tick,
    input  logic          ovf_clr,
    input  logic          mem_req,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_addr,
    input  logic [W-1:0]  mem_wdata,
    output logic          mem_gnt,
    output logic [W-1:0]  mem_rdata,
    output logic          rtc_ovf
);
    localparam logic [AW-1:0] CNT_A = AW'(RTC_ADDR);

    logic [W-1:0] store [DEPTH];
    logic         steal;
    logic [W-1:0] cnt_word;

    assign cnt_word = store[CNT_A];
    assign mem_gnt  = mem_req && !steal;

    always_ff @(posedge clk) begin
        if (rst) begin
            steal     <= 1'b0;
            rtc_ovf   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            steal <= rtc_tick;
            if (steal) begin
                store[CNT_A] <= cnt_word + 1'b1;
                if (&cnt_word)    rtc_ovf <= 1'b1;
                else if (ovf_clr) rtc_ovf <= 1'b0;
            end else begin
                if (ovf_clr) rtc_ovf <= 1'b0;
                if (mem_gnt) begin
                    if (mem_we) store[mem_addr] <= mem_wdata;
                    else        mem_rdata       <= store[mem_addr];
                end
            end
        end
    end
endmodule

// File: rtl/iot_ctrl.sv
module iot_ctrl
    import iot_pkg::*;
#(
    parameter int NDEV      = 4,
    parameter int DEV_BASE  = 1,
    parameter int MEM_DEPTH = 64,
    parameter int RTC_ADDR  = 7,
    localparam int AW       = $clog2(MEM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_start,
    input  logic              instr_valid,
    input  logic [17:0]       instr,
    input  logic [17:0]       acc,
    output logic              busy,
    output logic [NDEV-1:0]   dev_sel,
    output logic [2:0]        iop,
    output logic [17:0]       dout,
    output logic [NDEV-1:0]   dout_ld,
    input  logic [NDEV*18-1:0] din,
    output logic [17:0]       din_word,
    output logic              din_valid,
    input  logic [NDEV-1:0]   dev_flag,
    output logic              skip,
    input  logic              irq_ack,
    output logic              irq_en,
    output logic              irq_req,
    input  logic              rtc_tick,
    output logic              rtc_ovf,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [AW-1:0]     mem_addr,
    input  logic [17:0]       mem_wdata,
    output logic              mem_gnt,
    output logic [17:0]       mem_rdata
);
    iot_cmd_t cur;
    logic     ctl_hit;

    iot_seq u_seq (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
        .acc(acc), .busy(busy), .iop(iop), .cur(cur)
    );

    assign dout    = cur.data;
    assign ctl_hit = busy && (cur.code == CTL_CODE);

    iot_gather #(.NDEV(NDEV), .DEV_BASE(DEV_BASE)) u_gather (
        .clk(clk), .rst(rst), .busy(busy), .code(cur.code), .iop(iop),
        .dev_flag(dev_flag), .din(din), .dev_sel(dev_sel),
        .dout_ld(dout_ld), .skip(skip), .din_word(din_word),
        .din_valid(din_valid)
    );

    iot_irq u_irq (
        .clk(clk), .rst(rst), .cpu_start(cpu_start), .irq_ack(irq_ack),
        .en_on(ctl_hit && iop[1]), .en_off(ctl_hit && iop[0]),
        .flag_any(|dev_flag), .rtc_ovf(rtc_ovf),
        .irq_en(irq_en), .irq_req(irq_req)
    );

    iot_mem #(.DEPTH(MEM_DEPTH), .RTC_ADDR(RTC_ADDR)) u_mem (
        .clk(clk), .rst(rst), .rtc_tick(rtc_tick),
        .ovf_clr(ctl_hit && iop[2]), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .rtc_ovf(rtc_ovf)
    );
endmodule

// File: rtl/iot_ctrl_chk.sv
module iot_ctrl_chk #(
    parameter int NDEV = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic [2:0]      iop,
    input logic [NDEV-1:0] dev_sel,
    input logic [NDEV-1:0] dout_ld,
    input logic            skip,
    input logic            din_valid,
    input logic            irq_ack,
    input logic            cpu_start,
    input logic            irq_en,
    input logic            irq_req,
    input logic            rtc_tick,
    input logic            mem_gnt
);
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dev_sel));
    a_r2_sel_in_busy: assert property (@(posedge clk) disable iff (rst)
        (|dev_sel) |-> busy);
    a_r3_three_slots: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy ##1 busy ##1 !busy);
    a_r3_pulse_in_busy: assert property (@(posedge clk) disable iff (rst)
        (|iop) |-> busy);
    a_r4_ld_slot: assert property (@(posedge clk) disable iff (rst)
        (|dout_ld) |-> (iop[2] && $onehot(dout_ld)));
    a_r5_din_after_b1: assert property (@(posedge clk) disable iff (rst)
        din_valid |-> $past(iop[1]));
    a_r6_skip_slot: assert property (@(posedge clk) disable iff (rst)
        skip |-> iop[0]);
    a_r7_req_needs_en: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq_en);
    a_r9_en_dropped: assert property (@(posedge clk) disable iff (rst)
        (irq_ack || cpu_start) |=> !irq_en);
    a_r10_steal: assert property (@(posedge clk) disable iff (rst)
        rtc_tick |=> !mem_gnt);
endmodule

bind iot_ctrl iot_ctrl_chk #(.NDEV(NDEV)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .iop(iop), .dev_sel(dev_sel),
    .dout_ld(dout_ld), .skip(skip), .din_valid(din_valid),
    .irq_ack(irq_ack), .cpu_start(cpu_start), .irq_en(irq_en),
    .irq_req(irq_req), .rtc_tick(rtc_tick), .mem_gnt(mem_gnt)
);

// File: tb/iot_ctrl_bench.sv
module iot_ctrl_bench;
    localparam int  CLK_PERIOD = 10;
    localparam int  NDEV = 4;
    localparam int  AW   = 6;

    typedef struct packed {
        logic [5:0]      code;
        logic [2:0]      cmd;
        logic [17:0]     acc;
        logic [NDEV-1:0] flags;
        logic [NDEV-1:0] exp_sel;
        logic            exp_skip;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{6'd1, 3'b111, 18'o123456, 4'b0001, 4'b0001, 1'b1},
        '{6'd3, 3'b101, 18'o000777, 4'b0001, 4'b0100, 1'b0},
        '{6'd4, 3'b001, 18'o000000, 4'b1000, 4'b1000, 1'b1},
        '{6'd2, 3'b110, 18'o654321, 4'b0010, 4'b0010, 1'b0},
        '{6'd9, 3'b111, 18'o111111, 4'b1111, 4'b0000, 1'b0},
        '{6'd4, 3'b100, 18'o770000, 4'b0000, 4'b1000, 1'b0}
    };

    logic clk = 0, rst = 1, cpu_start = 0, instr_valid = 0;
    logic [17:0] instr = 0, acc = 0;
    logic busy, din_valid, skip, irq_en, irq_req, rtc_ovf, mem_gnt;
    logic [NDEV-1:0] dev_sel, dout_ld;
    logic [NDEV-1:0] dev_flag = 0;
    logic [2:0] iop;
    logic [17:0] dout, din_word, mem_rdata;
    logic [NDEV*18-1:0] din;
    logic irq_ack = 0, rtc_tick = 0, mem_req = 0, mem_we = 0;
    logic [AW-1:0] mem_addr = 0;
    logic [17:0] mem_wdata = 0;

    int total = 0, bad = 0;
    bit done = 0;

    localparam logic [17:0] DIN_OR = 18'o000421;
    assign din = {18'o000000, 18'o000400, 18'o000020, 18'o000001};

    always #(CLK_PERIOD/2) clk = ~clk;

    iot_ctrl u_iot_ctrl (
        .clk(clk), .rst(rst), .cpu_start(cpu_start), .instr_valid(instr_valid),
        .instr(instr), .acc(acc), .busy(busy), .dev_sel(dev_sel), .iop(iop),
        .dout(dout), .dout_ld(dout_ld), .din(din), .din_word(din_word),
        .din_valid(din_valid), .dev_flag(dev_flag), .skip(skip),
        .irq_ack(irq_ack), .irq_en(irq_en), .irq_req(irq_req),
        .rtc_tick(rtc_tick), .rtc_ovf(rtc_ovf), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] mk(input logic [5:0] code, input logic [2:0] cmd);
        return {6'o70, code, 3'b000, cmd};
    endfunction

    // Issue at a negedge; returns at the negedge after the sequence ends.
    task automatic run_iot(input logic [5:0] code, input logic [2:0] cmd,
                           input logic [17:0] a, input logic [NDEV-1:0] fl,
                           input logic [NDEV-1:0] esel, input logic eskip);
        instr = mk(code, cmd); acc = a; dev_flag = fl; instr_valid = 1;
        @(negedge clk);
        // slot 0; offer another instruction that must be ignored (R1)
        instr = mk(6'd1, 3'b111);
        chk("R2 sel", dev_sel, esel);
        chk("R3 iop b0", iop, {2'b00, cmd[0]});
        chk("R6 skip", skip, eskip);
        @(negedge clk);
        chk("R3 iop b1", iop, {1'b0, cmd[1], 1'b0});
        @(negedge clk);
        instr_valid = 0;
        chk("R3 iop b2", iop, {cmd[2], 2'b00});
        chk("R4 ld", dout_ld, cmd[2] ? esel : '0);
        chk("R4 dout", dout, a);
        chk("R5 din_valid", din_valid, cmd[1]);
        if (cmd[1]) chk("R5 din_word", din_word, DIN_OR);
        @(negedge clk);
        chk("R1 R3 busy ends", busy, 0);
        chk("R5 valid one cycle", din_valid, 0);
        dev_flag = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk("R9 reset en", irq_en, 0);
        chk("R3 reset busy", busy, 0);
        chk("R11 reset ovf", rtc_ovf, 0);

        for (int i = 0; i < NV; i++)
            run_iot(VEC[i].code, VEC[i].cmd, VEC[i].acc, VEC[i].flags,
                    VEC[i].exp_sel, VEC[i].exp_skip);

        // R1: non-IOT opcode ignored
        instr = {6'o71, 6'd1, 6'o7}; instr_valid = 1;
        @(negedge clk);
        chk("R1 non-iot busy", busy, 0);
        chk("R1 non-iot iop", iop, 0);
        instr_valid = 0;
        @(negedge clk);

        // R8/R7: enable, then flag raises request
        run_iot(6'd0, 3'b010, 0, 0, 0, 0);
        chk("R8 enable on", irq_en, 1);
        dev_flag = 4'b0010;
        #1 chk("R7 req flag", irq_req, 1);
        irq_ack = 1;
        @(negedge clk);
        irq_ack = 0;
        chk("R9 ack clears", irq_en, 0);
        chk("R7 req gone", irq_req, 0);
        dev_flag = 0;
        run_iot(6'd0, 3'b010, 0, 0, 0, 0);
        cpu_start = 1;
        @(negedge clk);
        cpu_start = 0;
        chk("R9 start clears", irq_en, 0);
        run_iot(6'd0, 3'b010, 0, 0, 0, 0);
        run_iot(6'd0, 3'b001, 0, 0, 0, 0);
        chk("R8 bit0 clears", irq_en, 0);

        // R12: write and read counter word
        mem_req = 1; mem_we = 1; mem_addr = 6'd7; mem_wdata = 18'o777776;
        #1 chk("R12 gnt", mem_gnt, 1);
        @(negedge clk);
        mem_we = 0;
        @(negedge clk);
        chk("R12 read", mem_rdata, 18'o777776);
        mem_req = 0;

        // R10: tick steals the next cycle
        rtc_tick = 1;
        @(negedge clk);
        rtc_tick = 0; mem_req = 1;
        #1 chk("R10 no grant", mem_gnt, 0);
        @(negedge clk);
        chk("R10 grant back", mem_gnt, 1);
        @(negedge clk);
        chk("R10 incremented", mem_rdata, 18'o777777);
        chk("R11 no ovf yet", rtc_ovf, 0);
        mem_req = 0;

        // R11: wrap to zero sets overflow
        run_iot(6'd0, 3'b010, 0, 0, 0, 0);
        rtc_tick = 1;
        @(negedge clk);
        rtc_tick = 0;
        @(negedge clk);
        chk("R11 ovf set", rtc_ovf, 1);
        chk("R7 req ovf", irq_req, 1);
        mem_req = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 wrapped", mem_rdata, 0);
        mem_req = 0;
        run_iot(6'd0, 3'b100, 0, 0, 0, 0);
        chk("R8 ovf cleared", rtc_ovf, 0);
        chk("R7 req clear", irq_req, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule